// File: doc/BRIEF.md
# SDRAM Single-Read Burst Sequencer

This sequencer sits on the controller side of an SDRAM interface and performs one isolated read. The memory is always programmed for burst operation, so even a read that wants one word makes the device drive a whole burst. On a request the block opens the row, waits one cycle, and issues the column read. It waits out the CAS latency and captures the first data beat. It then stays idle through the remaining beats so that stale data cannot meet another transfer on the data bus. After that it closes the bank with a precharge and waits out the precharge time before it accepts the next request.

The bus master sees a request line, a flat address and a one-cycle ready pulse that carries the captured word. The memory side has clock enable, the four command strobes, the bank and address lines, the byte masks and the data input. A capture strobe marks the single data cycle whose beat is kept. Writes, refresh, power-down, initialization and bank interleaving are handled elsewhere.

Top module: `sdram_single_rd`

## Requirements
- R1: After reset the command is NOP ({cs_n,ras_n,cas_n,we_n} = 0111), rdy_o and cap_o are low, every dqm_o bit is high and cke_o is high.
- R2: A request seen in idle at a clock edge produces ACTIVE (0011) in the next cycle, with ba_o = addr_i[24:23] and a_o = addr_i[22:10] (the row).
- R3: ACTIVE is followed by exactly one NOP cycle, then READ (0101) with ba_o equal to the bank, a_o[9:0] equal to addr_i[9:0], and every other a_o bit zero (bit 10 low: no auto-precharge).
- R4: cap_o is high for exactly one cycle, the third cycle after READ (CAS latency 3). That cycle is the first of four data cycles.
- R5: rdata_o is loaded from dq_i in the cap_o cycle only. dq_i values in the three following data cycles do not change it.
- R6: rdy_o pulses high for exactly one cycle, the cycle after cap_o, and rdata_o then holds the captured beat.
- R7: The command is NOP in every cycle between READ and the end of the burst. PRECHARGE (0010) follows in the cycle after the fourth data cycle, with ba_o equal to the bank and a_o bit 10 equal to parameter PRE_ALL (default 0, single bank) and all other a_o bits zero.
- R8: Two NOP cycles follow PRECHARGE. A request held high during an access is not taken until the cycle after the last precharge cycle, so ACTIVE reappears no earlier than 13 cycles after the previous ACTIVE.
- R9: Changes on addr_i after the request has been taken do not affect ba_o or a_o for that access.
- R10: dqm_o is all zeros from the READ cycle through the fourth data cycle and all ones in every other cycle. cke_o stays high.
- R11: Between accesses rdata_o keeps the last captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, taken only when idle |
| addr_i | input | 25 | {bank, row, column} request address |
| rdy_o | output | 1 | One-cycle pulse: rdata_o valid |
| rdata_o | output | 64 | Captured read word |
| cap_o | output | 1 | High in the one data cycle whose beat is kept |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| a_o | output | 13 | Row / column / precharge-mode address |
| dqm_o | output | 8 | Byte masks |
| dq_i | input | 64 | SDRAM read data |

## Verification
The bench drives a marked word on dq_i only in the expected first data cycle and random junk in every other cycle. A design that latches one cycle late, or reloads during the dummy beats, therefore returns the wrong word. Some accesses hold the request and scramble the address all through the sequence. A sequencer that re-arms before the last precharge cycle, or that reads the live address, then shows an early ACTIVE or wrong bank and row bits. Addresses at all-zeros and all-ones, back-to-back requests and random patterns check the row, column and precharge-bit placement. They also check that the byte masks open exactly over the READ-to-last-beat window.

// File: rtl/sdram_single_rd.sv
module sdram_single_rd #(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 64,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int PRE_CYC   = 3,
  parameter int AP_BIT    = 10,
  parameter bit PRE_ALL   = 1'b0,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int DQM_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cap_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [DQM_W-1:0]  dqm_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int CNT_W = $clog2(CAS_LAT + BURST_LEN + PRE_CYC + 1);
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_PRE = 4'b0010;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RWT, S_CAS, S_DAT, S_PRE} st_t;

  st_t st;
  logic [CNT_W-1:0]  cnt;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [3:0]        cmd;
  logic              first;

  assign first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      rdata_o <= '0;
      rdy_o   <= 1'b0;
    end else begin
      rdy_o <= (st == S_DAT) && first;
      case (st)
        S_IDLE: if (req_i) begin
          {bank_q, row_q, col_q} <= addr_i;
          st <= S_ACT;
        end
        S_ACT: st <= S_RWT;
        S_RWT: begin
          st  <= S_CAS;
          cnt <= '0;
        end
        S_CAS: if (cnt == CNT_W'(CAS_LAT - 1)) begin
          st  <= S_DAT;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_DAT: begin
          if (first) rdata_o <= dq_i;
          if (cnt == CNT_W'(BURST_LEN - 1)) begin
            st  <= S_PRE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_PRE: if (cnt == CNT_W'(PRE_CYC - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd = C_NOP;
    a_o = '0;
    case (st)
      S_ACT: begin cmd = C_ACT; a_o = row_q; end
      S_CAS: if (first) begin cmd = C_RD; a_o = ROW_W'(col_q); end
      S_PRE: if (first) begin cmd = C_PRE; a_o = ROW_W'(PRE_ALL) << AP_BIT; end
      default: ;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign ba_o  = (st == S_IDLE) ? '0 : bank_q;
  assign cap_o = (st == S_DAT) && first;
  assign dqm_o = (st == S_CAS || st == S_DAT) ? '0 : '1;
  assign cke_o = 1'b1;

  // R4
  cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> !cap_o);
  // R6
  rdy_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> $past(cap_o));
  // R8
  act_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |-> $past(st == S_IDLE && req_i));
  // R8
  pre_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |=> (cmd == C_NOP));
  // R3
  act_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT) |=> (cmd == C_NOP));
  // R10
  dqm_open_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> (dqm_o == '0));
endmodule

// File: tb/sim_sdram_single_rd.sv
`timescale 1ns/1ps
module sim_sdram_single_rd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [24:0] addr_i = '0;
  logic [63:0] dq_i = '0;
  logic        rdy_o, cap_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [63:0] rdata_o;
  logic [1:0]  ba_o;
  logic [12:0] a_o;
  logic [7:0]  dqm_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [63:0] last_word = '0;

  always #2.5 clk = ~clk;

  sdram_single_rd u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .rdy_o(rdy_o), .rdata_o(rdata_o), .cap_o(cap_o), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .ba_o(ba_o), .a_o(a_o), .dqm_o(dqm_o), .dq_i(dq_i));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int k);
    case (k)
      1: return 4'b0011;
      3: return 4'b0101;
      10: return 4'b0010;
      default: return 4'b0111;
    endcase
  endfunction

  function automatic string cmd_tag(input int k);
    if (k == 1) return "R2 command";
    if (k <= 3) return "R3 command";
    if (k <= 10) return "R7 command";
    return "R8 command";
  endfunction

  function automatic logic [12:0] exp_a(input int k, input logic [24:0] ad);
    if (k == 1) return ad[22:10];
    if (k == 3) return {3'b000, ad[9:0]};
    return 13'd0;
  endfunction

  task automatic do_read(input logic [24:0] ad, input bit hold);
    logic [63:0] w0 = {$urandom, $urandom};
    logic [3:0]  c;
    @(negedge clk);
    req_i = 1'b1; addr_i = ad; dq_i = {$urandom, $urandom};
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (hold) begin req_i = 1'b1; addr_i = 25'($urandom); end
      else req_i = 1'b0;
      dq_i = (k == 6) ? w0 : {$urandom, $urandom};
      c = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
      chk(c == exp_cmd(k), cmd_tag(k), 64'(c), 64'(exp_cmd(k)));
      if (k == 1 || k == 3 || k == 10) begin
        chk(ba_o == ad[24:23], hold ? "R9 bank" : "R2 R3 R7 bank", 64'(ba_o), 64'(ad[24:23]));
        chk(a_o == exp_a(k, ad), hold ? "R9 address" : "R2 R3 R7 address", 64'(a_o), 64'(exp_a(k, ad)));
      end
      chk(cap_o == (k == 6), "R4 capture strobe", 64'(cap_o), 64'(k == 6));
      chk(rdy_o == (k == 7), "R6 ready pulse", 64'(rdy_o), 64'(k == 7));
      if (k >= 7) chk(rdata_o == w0, "R5 R6 captured word", rdata_o, w0);
      chk(dqm_o == ((k >= 3 && k <= 9) ? 8'h00 : 8'hff), "R10 dqm", 64'(dqm_o),
          64'((k >= 3 && k <= 9) ? 8'h00 : 8'hff));
      chk(cke_o == 1'b1, "R10 cke", 64'(cke_o), 64'd1);
    end
    req_i = 1'b0;
    last_word = w0;
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dq_i = {$urandom, $urandom};
      chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R11 idle command",
          64'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 64'h7);
      chk(rdata_o == last_word, "R11 word held", rdata_o, last_word);
      chk(dqm_o == 8'hff, "R10 idle dqm", 64'(dqm_o), 64'hff);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R1 reset command",
        64'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 64'h7);
    chk(rdy_o == 1'b0 && cap_o == 1'b0, "R1 reset strobes", 64'({rdy_o, cap_o}), 64'h0);
    chk(dqm_o == 8'hff, "R1 reset dqm", 64'(dqm_o), 64'hff);
    chk(cke_o == 1'b1, "R1 reset cke", 64'(cke_o), 64'h1);
    chk(rdata_o == 64'h0, "R1 reset data", rdata_o, 64'h0);

    do_read(25'h0, 1'b0);
    idle_gap(2);
    do_read(25'h1ff_ffff, 1'b0);
    do_read(25'h155_5555, 1'b1);
    do_read(25'h0aa_aaaa, 1'b0);
    idle_gap(3);
    for (int i = 0; i < 40; i++) begin
      do_read(25'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) idle_gap(1 + int'($urandom % 3));
    end
    idle_gap(2);
    finish_up();
  end
endmodule